// File: doc/BRIEF.md
# Banked Ping-Pong Stream Buffer

This block is a double-buffered storage stage for vectors of `VEC_LEN` words that move through a datapath `BANKS` words per cycle. Storage is `BANKS` separate banks. Each bank has one write port and one read port, and holds `2*VEC_LEN/BANKS` words, split into a lower half and an upper half. One side of the buffer follows the stream. Stream beat `k` of a vector touches offset `k` of every bank, so element `i` of the vector lives in bank `i mod BANKS` at offset `floor(i/BANKS)`. The other side of the buffer takes a separate offset for each bank on every cycle. That side is used to gather or scatter words in any order for which the per-bank accesses never collide.

A half-select bit is kept by a two-state machine. State `HALF_LO` sends the streaming side to the lower half, and state `HALF_HI` sends it to the upper half. The transition `HALF_LO -> HALF_HI` fires on the accepted stream beat that carries the last offset. The transition `HALF_HI -> HALF_LO` fires on the same condition. Cycles without a stream beat leave both the state and the offset unchanged. The per-bank side always uses the inverted half-select, so it reaches the vector that the streaming side completed in the previous period. Vectors can therefore follow one another with no gap and no hazard.

The parameter `MODE` chooses the role of the block. With `MODE=0` the stream writes and the per-bank side reads, which is the gather stage at the front of a reordering pipe. With `MODE=1` the per-bank side writes and the stream reads, which is the scatter stage at its back. Reads are synchronous. `rd_data_o` and `rd_vld_o` appear one cycle after the read request.

Top module: `pp_stream_bank_buf`

## Requirements
- R1: After reset, `rd_vld_o` is 0, the machine is in `HALF_LO`, and the stream offset is 0.
- R2: In `MODE=0`, stream beat `k` of a vector writes lane `b` of `strm_data_i` (bits `b*DATA_W` upward) into bank `b` at offset `k` of the current half, so element `i` lands in bank `i mod BANKS` at offset `floor(i/BANKS)`.
- R3: The half-select flips only on the accepted stream beat whose offset is `VEC_LEN/BANKS-1`. A cycle with `strm_vld_i` low moves neither the offset nor the half.
- R4: The per-bank side always works on the half opposite the streaming side. In `MODE=0`, a read during period `p` returns the vector written during period `p-1`.
- R5: A read request (`rnd_vld_i` in `MODE=0`, `strm_vld_i` in `MODE=1`) raises `rd_vld_o` exactly one cycle later. A cycle with no request drives `rd_vld_o` low one cycle later.
- R6: Each bank `b` takes its own offset from `rnd_addr_i` bits `b*OFF_W` upward, with `OFF_W = max(1, ceil(log2(VEC_LEN/BANKS)))`. The data it reads appears on lane `b` of `rd_data_o`.
- R7: In `MODE=1`, a per-bank write stores lane `b` of `rnd_data_i` into bank `b` at the given offset of the opposite half. Stream beat `k` of the next period returns, on lane `b`, the word stored at offset `k` of bank `b`.
- R8: Vectors can stream back to back with no idle cycle. Writing a new vector never disturbs the previous vector while it is being read.
- R9: In a cycle with no read request, `rd_data_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strm_vld_i | input | 1 | Stream beat: a write in MODE 0, a read in MODE 1 |
| strm_data_i | input | BANKS*DATA_W | Stream write data, lane b goes to bank b (MODE 0) |
| rnd_vld_i | input | 1 | Per-bank access: a read in MODE 0, a write in MODE 1 |
| rnd_addr_i | input | BANKS*OFF_W | Per-bank offsets within the opposite half |
| rnd_data_i | input | BANKS*DATA_W | Per-bank write data (MODE 1) |
| rd_vld_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | BANKS*DATA_W | Read data, lane b comes from bank b |

## Verification
The bench writes vectors back to back and reads each one in the next period. The per-bank offsets come from scrambled tables in which every bank visits all offsets in its own order. A swapped half, a wrong bank lane or a stale read latency therefore shows up as a wrong word on a specific lane. Idle stream cycles are placed in the middle of a vector. A counter that advanced on idle cycles, or a half that flipped early, would put the rest of the vector at the wrong offsets, and the next period's reads would return the wrong words. The bench also checks the cycles with no request, looking for a spurious valid and for read data that changes. Both modes run: a scatter stage that wrote into the half being streamed out would return the new vector one period too early.

// File: rtl/pp_buf_pkg.sv
package pp_buf_pkg;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_state_e;

    localparam int MODE_STREAM_WR = 0;
    localparam int MODE_STREAM_RD = 1;

    function automatic int clog2_min1(input int value);
        int r;
        r = $clog2(value);
        return (r < 1) ? 1 : r;
    endfunction

endpackage

// File: rtl/pp_stream_seq.sv
module pp_stream_seq #(
    parameter int HALF_DEPTH = 4,
    parameter int OFF_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic             half_o,
    output logic [OFF_W-1:0] off_o
);
    import pp_buf_pkg::*;

    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(HALF_DEPTH - 1);

    half_state_e      state_q, state_d;
    logic [OFF_W-1:0] cnt_q, cnt_d;
    logic             at_last;

    assign at_last = (cnt_q == LAST_OFF);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HALF_LO;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and offset
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (step_i) begin
            cnt_d = at_last ? '0 : cnt_q + OFF_W'(1);
        end
        unique case (state_q)
            HALF_LO: if (step_i && at_last) state_d = HALF_HI;
            HALF_HI: if (step_i && at_last) state_d = HALF_LO;
        endcase
    end

    // outputs
    always_comb begin
        off_o = cnt_q;
        unique case (state_q)
            HALF_LO: half_o = 1'b0;
            HALF_HI: half_o = 1'b1;
        endcase
    end

    // R2: an accepted beat short of the last offset moves to the next offset
    assert_off_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !at_last) |=> (off_o == $past(off_o) + OFF_W'(1)));

    // R3: the last beat of a period flips the half and wraps the offset
    assert_half_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && at_last) |=> ((half_o != $past(half_o)) && (off_o == '0)));

    // R3: an idle cycle moves nothing
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(half_o) && $stable(off_o)));

endmodule

// File: rtl/pp_half_addr.sv
module pp_half_addr #(
    parameter int HALF_DEPTH = 4,
    parameter int OFF_W      = 2,
    parameter int BANK_AW    = 3
) (
    input  logic               half_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [BANK_AW-1:0] addr_o
);
    localparam logic [BANK_AW-1:0] HALF_BASE = BANK_AW'(HALF_DEPTH);

    always_comb begin
        if (half_i) addr_o = BANK_AW'(off_i) + HALF_BASE;
        else        addr_o = BANK_AW'(off_i);
    end

endmodule

// File: rtl/pp_bank_ram.sv
module pp_bank_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (re_i) rdata_o <= mem[raddr_i];
    end

endmodule

// File: rtl/pp_stream_bank_buf.sv
module pp_stream_bank_buf #(
    parameter int DATA_W  = 8,
    parameter int BANKS   = 4,
    parameter int VEC_LEN = 16,
    parameter int MODE    = 0,
    localparam int HALF_DEPTH = VEC_LEN / BANKS,
    localparam int OFF_W      = pp_buf_pkg::clog2_min1(HALF_DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    strm_vld_i,
    input  logic [BANKS*DATA_W-1:0] strm_data_i,
    input  logic                    rnd_vld_i,
    input  logic [BANKS*OFF_W-1:0]  rnd_addr_i,
    input  logic [BANKS*DATA_W-1:0] rnd_data_i,
    output logic                    rd_vld_o,
    output logic [BANKS*DATA_W-1:0] rd_data_o
);
    import pp_buf_pkg::*;

    localparam int BANK_DEPTH = 2 * HALF_DEPTH;
    localparam int BANK_AW    = clog2_min1(BANK_DEPTH);

    logic               strm_half;
    logic [OFF_W-1:0]   strm_off;
    logic [BANK_AW-1:0] strm_bank_addr;
    logic               read_req;
    logic               rd_vld_q;

    pp_stream_seq #(
        .HALF_DEPTH (HALF_DEPTH),
        .OFF_W      (OFF_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (strm_vld_i),
        .half_o (strm_half),
        .off_o  (strm_off)
    );

    pp_half_addr #(
        .HALF_DEPTH (HALF_DEPTH),
        .OFF_W      (OFF_W),
        .BANK_AW    (BANK_AW)
    ) u_strm_addr (
        .half_i (strm_half),
        .off_i  (strm_off),
        .addr_o (strm_bank_addr)
    );

    generate
        if (MODE == MODE_STREAM_WR) begin : g_req_gather
            assign read_req = rnd_vld_i;
            logic unused_rnd_data;
            assign unused_rnd_data = ^rnd_data_i;
        end else begin : g_req_scatter
            assign read_req = strm_vld_i;
            logic unused_strm_data;
            assign unused_strm_data = ^strm_data_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) rd_vld_q <= 1'b0;
        else        rd_vld_q <= read_req;
    end
    assign rd_vld_o = rd_vld_q;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [OFF_W-1:0]   rnd_off;
        logic [BANK_AW-1:0] rnd_bank_addr;
        logic               we, re;
        logic [BANK_AW-1:0] wa, ra;
        logic [DATA_W-1:0]  wd;

        assign rnd_off = rnd_addr_i[b*OFF_W +: OFF_W];

        pp_half_addr #(
            .HALF_DEPTH (HALF_DEPTH),
            .OFF_W      (OFF_W),
            .BANK_AW    (BANK_AW)
        ) u_rnd_addr (
            .half_i (~strm_half),
            .off_i  (rnd_off),
            .addr_o (rnd_bank_addr)
        );

        if (MODE == MODE_STREAM_WR) begin : g_gather
            assign we = strm_vld_i;
            assign wa = strm_bank_addr;
            assign wd = strm_data_i[b*DATA_W +: DATA_W];
            assign re = rnd_vld_i;
            assign ra = rnd_bank_addr;
        end else begin : g_scatter
            assign we = rnd_vld_i;
            assign wa = rnd_bank_addr;
            assign wd = rnd_data_i[b*DATA_W +: DATA_W];
            assign re = strm_vld_i;
            assign ra = strm_bank_addr;
        end

        pp_bank_ram #(
            .DATA_W (DATA_W),
            .DEPTH  (BANK_DEPTH),
            .AW     (BANK_AW)
        ) u_ram (
            .clk     (clk),
            .we_i    (we),
            .waddr_i (wa),
            .wdata_i (wd),
            .re_i    (re),
            .raddr_i (ra),
            .rdata_o (rd_data_o[b*DATA_W +: DATA_W])
        );

        // R8: a write and a read in the same cycle never meet at one word
        assert_no_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (we && re) |-> (wa != ra));
    end

    // R5: valid follows the request by one cycle
    assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        read_req |=> rd_vld_o);
    assert_no_spurious_vld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !read_req |=> !rd_vld_o);

    // R9: read data holds when nothing is read
    assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !read_req |=> $stable(rd_data_o));

endmodule

// File: tb/sim_pp_stream_bank_buf.sv
`timescale 1ns/1ps
module sim_pp_stream_bank_buf;

    localparam int DW    = 8;
    localparam int NB    = 4;
    localparam int NV    = 16;
    localparam int OW    = 2;
    localparam int LANES = NB * DW;

    // Per-cycle bank offsets, lane 3 in the top bits; each group of four
    // rows visits every offset once per bank.
    localparam logic [7:0] ADDR_TBL [8] = '{
        8'hD2, 8'h2D, 8'h78, 8'h87,
        8'h07, 8'h72, 8'h9C, 8'hE9
    };

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic             a_sv, a_rv, a_ov;
    logic [LANES-1:0] a_sd, a_rd, a_od;
    logic [NB*OW-1:0] a_ra;
    logic             b_sv, b_rv, b_ov;
    logic [LANES-1:0] b_sd, b_rd, b_od;
    logic [NB*OW-1:0] b_ra;

    pp_stream_bank_buf #(.DATA_W(DW), .BANKS(NB), .VEC_LEN(NV), .MODE(0)) u0 (
        .clk(clk), .rst_n(rst_n), .strm_vld_i(a_sv), .strm_data_i(a_sd),
        .rnd_vld_i(a_rv), .rnd_addr_i(a_ra), .rnd_data_i(a_rd),
        .rd_vld_o(a_ov), .rd_data_o(a_od));

    pp_stream_bank_buf #(.DATA_W(DW), .BANKS(NB), .VEC_LEN(NV), .MODE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .strm_vld_i(b_sv), .strm_data_i(b_sd),
        .rnd_vld_i(b_rv), .rnd_addr_i(b_ra), .rnd_data_i(b_rd),
        .rd_vld_o(b_ov), .rd_data_o(b_od));

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // stream order: lane b of beat k is element k*NB+b
    function automatic logic [LANES-1:0] stream_word(input int base, input int k);
        logic [LANES-1:0] r;
        for (int b = 0; b < NB; b++) r[b*DW +: DW] = 8'(base + k*NB + b);
        return r;
    endfunction

    // gathered order: bank b at offset a holds element a*NB+b
    function automatic logic [LANES-1:0] gather_word(input int base, input logic [7:0] ad);
        logic [LANES-1:0] r;
        for (int b = 0; b < NB; b++) r[b*DW +: DW] = 8'(base + int'(ad[b*OW +: OW])*NB + b);
        return r;
    endfunction

    task automatic cyc0(input logic sv, input logic [LANES-1:0] sd, input logic rv, input logic [7:0] ad);
        @(negedge clk);
        a_sv = sv; a_sd = sd; a_rv = rv; a_ra = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic cyc1(input logic sv, input logic rv, input logic [7:0] ad, input logic [LANES-1:0] wd);
        @(negedge clk);
        b_sv = sv; b_rv = rv; b_ra = ad; b_rd = wd;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [LANES-1:0] held;
        a_sv = 0; a_rv = 0; a_sd = '0; a_rd = '0; a_ra = '0;
        b_sv = 0; b_rv = 0; b_sd = '0; b_rd = '0; b_ra = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 gather rd_vld after reset", LANES'(a_ov), '0);
        chk("R1 scatter rd_vld after reset", LANES'(b_ov), '0);

        // gather mode: five vectors back to back, each read in the next period
        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] ad;
                ad = ADDR_TBL[(p % 2)*4 + k];
                cyc0(1'b1, stream_word(p*16, k), p > 0, ad);
                chk("R5 gather valid", LANES'(a_ov), LANES'(p > 0));
                if (p > 0)
                    chk("R2 R4 R6 R8 gather data", a_od, gather_word((p-1)*16, ad));
            end
        end

        // period 5: beats interleaved with idle cycles (R3)
        for (int k = 0; k < 2; k++) begin
            cyc0(1'b1, stream_word(80, k), 1'b1, ADDR_TBL[4 + k]);
            chk("R4 gather data before idle", a_od, gather_word(64, ADDR_TBL[4 + k]));
        end
        for (int k = 0; k < 3; k++) begin
            cyc0(1'b0, '0, 1'b1, ADDR_TBL[k]);
            chk("R3 idle keeps half", a_od, gather_word(64, ADDR_TBL[k]));
        end
        held = a_od;
        cyc0(1'b0, '0, 1'b0, 8'h00);
        chk("R5 no request no valid", LANES'(a_ov), '0);
        chk("R9 gather data held", a_od, held);
        for (int k = 2; k < 4; k++) begin
            cyc0(1'b1, stream_word(80, k), 1'b1, ADDR_TBL[4 + k]);
            chk("R4 gather data after idle", a_od, gather_word(64, ADDR_TBL[4 + k]));
        end
        for (int k = 0; k < 4; k++) begin
            cyc0(1'b1, stream_word(96, k), 1'b1, ADDR_TBL[k]);
            chk("R3 R2 vector with idle gap", a_od, gather_word(80, ADDR_TBL[k]));
        end
        cyc0(1'b0, '0, 1'b0, 8'h00);

        // scatter mode: per-bank writes, streamed out in the next period
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 4; k++) begin
                logic [7:0] ad;
                ad = ADDR_TBL[(p % 2)*4 + k];
                cyc1(1'b1, p < 3, ad, gather_word(128 + p*16, ad));
                chk("R5 scatter valid", LANES'(b_ov), LANES'(1));
                if (p > 0)
                    chk("R7 R8 scatter data", b_od, stream_word(128 + (p-1)*16, k));
            end
        end
        held = b_od;
        cyc1(1'b0, 1'b0, 8'h00, '0);
        chk("R5 scatter no request", LANES'(b_ov), '0);
        chk("R9 scatter data held", b_od, held);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule